// File: doc/BRIEF.md
# PHY Register Access Bridge

This block lets a host reach the 16-bit internal registers of a transceiver PHY through one 32-bit command/status word. The host writes the word to start an access. Bit 0 chooses the direction. Bits [15:8] hold the 8-bit PHY register address. Bits [31:16] hold the write data. The bridge then drives a simple parallel request/acknowledge port towards the PHY register file.

Reading the word back returns the state of the access. Bit 7 is the busy flag. Bit 6 reports an access that the PHY never acknowledged. Once busy drops, the upper half-word holds the value returned by a read. The host polls the busy flag before it uses any result.

An internal watchdog bounds every access to a parameterised number of cycles. That limit lies far inside the host's polling budget of tens of milliseconds, so the host always sees busy clear.

Top module: `phyreg_bridge`

## Requirements
- R1: After reset the status word reads 0 and `phy_req` is low.
- R2: A host write whose bit 0 is 1 issues a PHY write. `phy_we` is 1, `phy_addr` equals bits [15:8] of the command, and `phy_wdata` equals bits [31:16].
- R3: A host write whose bit 0 is 0 issues a PHY read of address [15:8]. On acknowledge, the returned 16-bit value appears in bits [31:16] of the status word.
- R4: Bit 7 (busy) reads 1 from the clock edge that accepts a command. It stays 1 until the edge that samples `phy_ack`, so an access acknowledged L cycles after the request rises keeps busy high for L+1 cycles.
- R5: `phy_req` is high exactly while busy, and `phy_addr`, `phy_we` and `phy_wdata` stay constant while it is high.
- R6: A host write while busy has no effect on the status word or on the PHY access in flight.
- R7: If no acknowledge arrives, busy clears after TIMEOUT_CYC cycles. At the same time bit 6 (error) is set and the PHY request drops.
- R8: The error bit stays set until the next accepted command, which clears it.
- R9: Read data in bits [31:16] holds its value until the next accepted command.
- R10: `phy_ack` while no request is pending has no effect.
- R11: Bits [5:1] of the status word always read 0, whatever the host wrote there. Bit 0 reads back the direction of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Command word written by the host |
| host_rdata | output | 32 | Status word read by the host |
| phy_req | output | 1 | Access request to the PHY register port |
| phy_we | output | 1 | 1 for a PHY write, 0 for a PHY read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | 16 | PHY read data, valid with `phy_ack` |

## Verification
The assertions assume that the PHY raises `phy_ack` only for one cycle, and only when it answers a pending request. They also assume that `phy_rdata` is valid in that same cycle. The stray-acknowledge case is the one exception, and it is driven on purpose while idle. The bench's PHY model pulses the acknowledge once per request after a programmable latency, or never, in order to exercise the watchdog. Host strobes are driven between clock edges, so the busy-time write is the only overlap with an access in flight.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int OP_POS   = 0;
  localparam int ERR_POS  = 6;
  localparam int BUSY_POS = 7;
  localparam int ADDR_LSB = 8;
  localparam int DATA_LSB = 16;

  typedef struct packed {
    logic              busy;
    logic              err;
    logic              op_wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } acc_state_t;

  function automatic logic [WORD_W-1:0] pack_status(acc_state_t s);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OP_POS]                      = s.op_wr;
    w[ERR_POS]                     = s.err;
    w[BUSY_POS]                    = s.busy;
    w[ADDR_LSB +: ADDR_W]          = s.addr;
    w[DATA_LSB +: DATA_W]          = s.data;
    return w;
  endfunction
endpackage

// File: rtl/phyreg_watchdog.sv
module phyreg_watchdog #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign expire = run && !start && (cnt == CW'(LIMIT - 1));

  // R7
  wd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/phyreg_ctrl.sv
module phyreg_ctrl
  import phyreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata,
  input  logic              expire,
  output logic              start,
  output acc_state_t        st
);
  assign start = cmd_we && !st.busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else if (start) begin
      st.busy  <= 1'b1;
      st.err   <= 1'b0;
      st.op_wr <= cmd_word[OP_POS];
      st.addr  <= cmd_word[ADDR_LSB +: ADDR_W];
      st.data  <= cmd_word[DATA_LSB +: DATA_W];
    end else if (st.busy) begin
      if (phy_ack) begin
        st.busy <= 1'b0;
        if (!st.op_wr) st.data <= phy_rdata;
      end else if (expire) begin
        st.busy <= 1'b0;
        st.err  <= 1'b1;
      end
    end
  end

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st.busy) |-> $past(cmd_we));
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st.busy && cmd_we |=> $stable(st.addr) && $stable(st.op_wr));
  // R7
  timeout_err_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(st.busy) && !$past(phy_ack) |-> st.err);
  // R8
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    st.err && !cmd_we |=> st.err);
  // R3
  rdata_load_chk: assert property (@(posedge clk) disable iff (rst)
    st.busy && !st.op_wr && phy_ack |=> st.data == $past(phy_rdata));
endmodule

// File: rtl/phyreg_bridge.sv
module phyreg_bridge
  import phyreg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata
);
  acc_state_t st;
  logic       start;
  logic       expire;

  phyreg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_we    (host_we),
    .cmd_word  (host_wdata),
    .phy_ack   (phy_ack),
    .phy_rdata (phy_rdata),
    .expire    (expire),
    .start     (start),
    .st        (st)
  );

  phyreg_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .run    (st.busy),
    .expire (expire)
  );

  assign host_rdata = pack_status(st);
  assign phy_req    = st.busy;
  assign phy_we     = st.op_wr;
  assign phy_addr   = st.addr;
  assign phy_wdata  = st.data;

  // R5
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    phy_req && $past(phy_req) |-> $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata));
  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !phy_req && !host_we |=> $stable(host_rdata));
endmodule

// File: tb/sim_phyreg_bridge.sv
module sim_phyreg_bridge;
  localparam int TO = 1024;

  logic        clk = 0;
  logic        rst = 1;
  logic        host_we = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we;
  logic [7:0]  phy_addr;
  logic [15:0] phy_wdata;
  logic        phy_ack = 0;
  logic [15:0] phy_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  phyreg_bridge #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata)
  );

  // behavioural PHY register file
  logic [15:0] mem [256];
  int  lat = 0;
  int  wcnt = 0;
  bit  stray = 0;
  bit  saw_we = 0;
  int  unstable = 0;
  logic [7:0] prev_addr;
  bit  prev_req = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A5A;

  always @(negedge clk) begin
    if (prev_req && phy_req && phy_addr != prev_addr) unstable++;
    prev_req  <= phy_req;
    prev_addr <= phy_addr;
    if (stray) begin
      phy_ack <= 1; phy_rdata <= 16'hDEAD;
    end else if (phy_ack) begin
      phy_ack <= 0; wcnt <= 0;
    end else if (phy_req && lat >= 0) begin
      if (wcnt == lat) begin
        phy_ack   <= 1;
        phy_rdata <= mem[phy_addr];
        if (phy_we) begin mem[phy_addr] <= phy_wdata; saw_we <= 1; end
        wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end
  end

  // cycle reference model
  bit m_busy, m_err, m_op;
  logic [7:0] m_addr;
  logic [15:0] m_data;
  int m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_err = 0; m_op = 0; m_addr = 0; m_data = 0; m_cnt = 0;
    end else if (!m_busy) begin
      if (host_we) begin
        m_busy = 1; m_err = 0; m_op = host_wdata[0];
        m_addr = host_wdata[15:8]; m_data = host_wdata[31:16]; m_cnt = 0;
      end
    end else if (phy_ack) begin
      m_busy = 0;
      if (!m_op) m_data = phy_rdata;
    end else if (m_cnt == TO - 1) begin
      m_busy = 0; m_err = 1;
    end else m_cnt++;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [31:0] e;
      e = {m_data, m_addr, m_busy, m_err, 5'b0, m_op};
      checks++;
      if (host_rdata !== e || phy_req !== m_busy) begin
        fails++;
        $display("FAIL R4 model: word %h req %b expected %h req %b", host_rdata, phy_req, e, m_busy);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [31:0] w);
    @(negedge clk); host_we = 1; host_wdata = w;
    @(negedge clk); host_we = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (host_rdata[7] && n < TO + 10) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int n;
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 word", host_rdata, 0);
    chk("R1 req", 32'(phy_req), 0);

    // R2 write, latency 3
    lat = 3;
    cmd({16'hA5C3, 8'h21, 8'h01});
    chk("R4 busy set", 32'(host_rdata[7]), 1);
    chk("R2 addr", 32'(phy_addr), 32'h21);
    chk("R2 we", 32'(phy_we), 1);
    chk("R2 wdata", 32'(phy_wdata), 32'hA5C3);
    wait_idle(n);
    chk("R4 busy cycles", n, 4);
    chk("R2 mem", 32'(mem[8'h21]), 32'hA5C3);
    chk("R2 we seen", 32'(saw_we), 1);

    // R3 read, latency 5, host junk in [6:1]
    lat = 5;
    cmd({16'h0000, 8'h21, 8'h7E});
    chk("R11 pad bits", 32'(host_rdata[6:1]), 0);
    wait_idle(n);
    chk("R4 busy cycles read", n, 6);
    chk("R3 rdata", 32'(host_rdata[31:16]), 32'hA5C3);
    chk("R11 op bit", 32'(host_rdata[0]), 0);

    // R9 hold
    keep = host_rdata[31:16];
    repeat (20) @(negedge clk);
    chk("R9 hold", 32'(host_rdata[31:16]), 32'(keep));

    // R6 write while busy ignored
    lat = 10;
    cmd({16'h0000, 8'h40, 8'h00});
    cmd({16'hFFFF, 8'h55, 8'h01});
    chk("R6 addr", 32'(host_rdata[15:8]), 32'h40);
    chk("R6 op", 32'(phy_we), 0);
    wait_idle(n);
    chk("R6 data", 32'(host_rdata[31:16]), 32'(16'h4040 ^ 16'h5A5A));
    chk("R6 mem", 32'(mem[8'h55]), 32'(16'h5555 ^ 16'h5A5A));
    chk("R5 stable", unstable, 0);

    // R10 stray ack while idle
    keep = host_rdata[31:16];
    @(negedge clk); stray = 1;
    @(negedge clk); stray = 0;
    repeat (2) @(negedge clk);
    chk("R10 data", 32'(host_rdata[31:16]), 32'(keep));
    chk("R10 busy", 32'(host_rdata[7]), 0);

    // R7 timeout
    lat = -1;
    cmd({16'h1111, 8'h10, 8'h01});
    wait_idle(n);
    chk("R7 busy cycles", n, TO);
    chk("R7 err", 32'(host_rdata[6]), 1);
    chk("R7 req", 32'(phy_req), 0);
    chk("R7 mem", 32'(mem[8'h10]), 32'(16'h1010 ^ 16'h5A5A));

    // R8 sticky then cleared
    repeat (5) @(negedge clk);
    chk("R8 sticky", 32'(host_rdata[6]), 1);
    lat = 0;
    cmd({16'h0000, 8'h10, 8'h00});
    chk("R8 cleared", 32'(host_rdata[6]), 0);
    wait_idle(n);
    chk("R4 busy one", n, 1);
    chk("R3 rdata2", 32'(host_rdata[31:16]), 32'(16'h1010 ^ 16'h5A5A));
    chk("R8 no err", 32'(host_rdata[6]), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule